// File: doc/BRIEF.md
# Real-Time-Clock Register Interface

This block is the register front end of a battery-style real-time clock, reached over an 8-bit bus through two ports: an index port and a data port. A write to the index port chooses one of fourteen locations. Accesses to the data port then reach either ten bytes of general clock-data storage or one of four status registers. Calendar counting is not part of this block. The storage simply returns whatever software last put there.

The status registers behave like a legacy clock. Register A has a fixed time-base and rate setting. Its update-in-progress flag flips on every read, so code that waits for that flag to change always sees progress. Register B holds the mode bits: binary mode and 24-hour mode are fixed, and only the periodic-interrupt enable and the square-wave enable may change. Registers C and D read as zero.

While the periodic-interrupt enable is set, a free-running interval timer gives a one-cycle interrupt pulse every `PERIOD_CYC` clock cycles. Any illegal access sets a sticky error output, and only reset clears it.

Top module: `rtc_regif`

## Requirements
- R1: An index-port write (`wr_i`=1, `sel_i`=0) with a value from 0x00 to 0x0D selects that location. A read of the index port (`rd_i`=1, `sel_i`=0) returns the current index in the low bits, with the upper bits zero. The index is 0x00 after reset.
- R2: An index-port write with a value above 0x0D leaves the index unchanged and sets `err_o`.
- R3: Locations 0x00 to 0x09 are byte storage. A data-port read returns the last byte written to that location, or 0x00 if the location has not been written since reset.
- R4: After reset, register A (location 0x0A) holds 0x26, and register B (location 0x0B) holds 0x46. In register B, bit 6 is the periodic-interrupt enable, bit 3 is the square-wave enable, bit 2 is binary mode and bit 1 is 24-hour mode. After reset, `rdata_o`, `irq_o` and `err_o` are 0.
- R5: Every data-port read of register A first inverts its bit 7 and then returns the new value. The first read after reset therefore returns 0xA6, and later reads alternate between 0x26 and 0xA6.
- R6: A write to register B is accepted only if the value ANDed with 0xB7 equals 0x06. Any other value is ignored and sets `err_o`.
- R7: A write to register A with 0x26 is accepted, which also clears bit 7. Any other value is ignored and sets `err_o`.
- R8: Data-port reads of locations 0x0C and 0x0D return 0x00. Writes to these locations change nothing and set `err_o`.
- R9: While bit 6 of register B is set, `irq_o` is high for exactly one cycle in every `PERIOD_CYC` cycles. The first pulse comes `PERIOD_CYC` cycles after reset is released.
- R10: While bit 6 of register B is clear, `irq_o` stays low. When the bit is set again, the first pulse comes `PERIOD_CYC` cycles after the write. Writing register B with bit 6 set while the timer is already running does not move the pulse schedule.
- R11: `err_o` stays set once it is raised, until reset.
- R12: `rdata_o` is registered: it takes the read value in the cycle after the read and otherwise holds. If `wr_i` and `rd_i` are both high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| sel_i | input | 1 | Port select: 0 index port, 1 data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Periodic interrupt pulse |
| err_o | output | 1 | Sticky illegal-access flag |

## Verification
The bench checks that the register A flag alternates across back-to-back reads. A design that toggled the flag after returning the value would give 0x26 first instead of 0xA6. Rejected index values and rejected status writes are read back through the ports to show they left no trace. A design that latched the index or register value anyway would return the wrong byte, and one that lost the error would show `err_o` low. The interrupt pulse spacing is measured after reset, after the enable is set again, and across a redundant enable write. A timer that restarted on any register B write, or that failed to clear its count while disabled, would show a spacing other than `PERIOD_CYC`.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned RAM_DEPTH = 10;
  localparam logic [7:0]  IDX_A     = 8'h0A;
  localparam logic [7:0]  IDX_B     = 8'h0B;
  localparam logic [7:0]  IDX_C     = 8'h0C;
  localparam logic [7:0]  IDX_D     = 8'h0D;
  localparam logic [7:0]  IDX_LAST  = IDX_D;
  localparam logic [7:0]  A_RST     = 8'h26;
  localparam logic [7:0]  B_RST     = 8'h46;
  localparam logic [7:0]  B_FIXED   = 8'h06;
  localparam logic [7:0]  B_FREE    = 8'h48;
  localparam int unsigned UIP_POS   = 7;
  localparam int unsigned PIE_POS   = 6;

  typedef enum logic [1:0] {ACC_NONE, ACC_WR, ACC_RD} acc_e;

  function automatic logic b_write_ok(input logic [7:0] v);
    return (v & ~B_FREE) == B_FIXED;
  endfunction
endpackage

// File: rtl/rtc_index.sv
module rtc_index
  import rtc_regif_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             bad_o
);
  logic [IDX_W-1:0] idx_q;

  assign bad_o = wr_i && (wdata_i > IDX_LAST);
  assign idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             idx_q <= '0;
    else if (wr_i && !bad_o) idx_q <= wdata_i[IDX_W-1:0];
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regif_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_e             acc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rd_val_o,
  output logic [7:0]       reg_b_o,
  output logic             bad_o
);
  localparam logic [IDX_W-1:0] I_A   = IDX_W'(IDX_A);
  localparam logic [IDX_W-1:0] I_B   = IDX_W'(IDX_B);
  localparam logic [IDX_W-1:0] I_C   = IDX_W'(IDX_C);
  localparam logic [IDX_W-1:0] I_D   = IDX_W'(IDX_D);
  localparam logic [IDX_W-1:0] I_TOP = IDX_W'(RAM_DEPTH);
  localparam logic [7:0]       UIP_M = 8'(1) << UIP_POS;

  logic [7:0]           ram_q [RAM_DEPTH];
  logic [RAM_DEPTH-1:0] ram_we;
  logic [7:0]           reg_a_q, reg_b_q;
  logic                 wr, rd, is_ram;
  logic                 a_ok, b_ok;

  assign wr     = (acc_i == ACC_WR);
  assign rd     = (acc_i == ACC_RD);
  assign is_ram = (idx_i < I_TOP);
  assign a_ok   = (wdata_i == A_RST);
  assign b_ok   = b_write_ok(wdata_i);

  for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_we
    assign ram_we[g] = wr && (idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
    end else begin
      for (int i = 0; i < RAM_DEPTH; i++)
        if (ram_we[i]) ram_q[i] <= wdata_i;
    end
  end

  // register A: fixed value, update flag flips on each read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         reg_a_q <= A_RST;
    else if (wr && idx_i == I_A && a_ok) reg_a_q <= wdata_i;
    else if (rd && idx_i == I_A)         reg_a_q <= reg_a_q ^ UIP_M;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         reg_b_q <= B_RST;
    else if (wr && idx_i == I_B && b_ok) reg_b_q <= wdata_i;
  end

  always_comb begin
    rd_val_o = '0;
    if (is_ram)            rd_val_o = ram_q[idx_i];
    else if (idx_i == I_A) rd_val_o = reg_a_q ^ UIP_M;
    else if (idx_i == I_B) rd_val_o = reg_b_q;
  end

  assign bad_o = wr && (((idx_i == I_A) && !a_ok) ||
                        ((idx_i == I_B) && !b_ok) ||
                        (idx_i == I_C) || (idx_i == I_D));
  assign reg_b_o = reg_b_q;
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int unsigned PERIOD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic irq_o
);
  localparam int unsigned     CNT_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  // count held at zero while disabled, so re-enable starts a full interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      irq_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_regif_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       sel_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       err_o
);
  localparam int unsigned IDX_W = $clog2(int'(IDX_LAST) + 1);

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       rf_val, reg_b, rdata_q;
  logic             bad_idx, bad_rf, err_q;
  acc_e             acc;

  always_comb begin
    acc = ACC_NONE;
    if (sel_i) begin
      if (wr_i)      acc = ACC_WR;
      else if (rd_i) acc = ACC_RD;
    end
  end

  rtc_index #(.IDX_W(IDX_W)) i_index (
    .clk_i, .rst_ni,
    .wr_i   (wr_i && !sel_i),
    .wdata_i,
    .idx_o  (idx_q),
    .bad_o  (bad_idx)
  );

  rtc_regfile #(.IDX_W(IDX_W)) i_regfile (
    .clk_i, .rst_ni,
    .acc_i    (acc),
    .idx_i    (idx_q),
    .wdata_i,
    .rd_val_o (rf_val),
    .reg_b_o  (reg_b),
    .bad_o    (bad_rf)
  );

  rtc_periodic #(.PERIOD_CYC(PERIOD_CYC)) i_periodic (
    .clk_i, .rst_ni,
    .en_i  (reg_b[PIE_POS]),
    .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (rd_i && !wr_i)  rdata_q <= sel_i ? rf_val : BYTE_W'(idx_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | bad_idx | bad_rf;
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rtc_regif_chk.sv
module rtc_regif_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_i,
  input logic       sel_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       err_o,
  input logic [3:0] idx,
  input logic [7:0] reg_b
);
  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx <= 4'hD); // R1
  AST_BAD_IDX_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i && wdata_i > 8'h0D) |=> err_o); // R2
  AST_BAD_IDX_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i && wdata_i > 8'h0D) |=> $stable(idx)); // R2
  AST_B_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_b & 8'hB7) == 8'h06); // R6
  AST_CD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && sel_i && idx >= 4'hC) |=> rdata_o == 8'h00); // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R9
  AST_IRQ_NEEDS_PIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_b[6] |=> !irq_o); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && !wr_i) |=> $stable(rdata_o)); // R12
endmodule

bind rtc_regif rtc_regif_chk i_rtc_regif_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .sel_i   (sel_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .err_o   (err_o),
  .idx     (idx_q),
  .reg_b   (reg_b)
);

// File: tb/test_rtc_regif.sv
`timescale 1ns/1ps
module test_rtc_regif;
  localparam int P = 16;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, err;

  int n_chk = 0, n_err = 0;

  rtc_regif #(.PERIOD_CYC(P)) i_rtc_regif (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .err_o(err)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  int m_idx, m_a, m_b, m_rd, m_cnt, w;
  int m_ram[10];
  bit m_irq, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_a = 'h26; m_b = 'h46; m_rd = 0; m_cnt = 0;
      m_irq = 0; m_err = 0;
      foreach (m_ram[i]) m_ram[i] = 0;
    end else begin
      w = int'(wdata);
      m_irq = m_b[6] && (m_cnt == P - 1);
      if (!m_b[6] || m_cnt == P - 1) m_cnt = 0; else m_cnt++;
      if (wr) begin
        if (!sel) begin
          if (w <= 'h0D) m_idx = w; else m_err = 1;
        end else if (m_idx < 10) m_ram[m_idx] = w;
        else if (m_idx == 'h0A) begin
          if (w == 'h26) m_a = w; else m_err = 1;
        end else if (m_idx == 'h0B) begin
          if ((w & 'hB7) == 'h06) m_b = w; else m_err = 1;
        end else m_err = 1;
      end else if (rd) begin
        if (!sel) m_rd = m_idx;
        else if (m_idx < 10) m_rd = m_ram[m_idx];
        else if (m_idx == 'h0A) begin m_a = m_a ^ 'h80; m_rd = m_a; end
        else if (m_idx == 'h0B) m_rd = m_b;
        else m_rd = 0;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R12 per-cycle rdata vs model", int'(rdata), m_rd);
      check("R9 per-cycle irq vs model", int'(irq), int'(m_irq));
      check("R11 per-cycle err vs model", int'(err), int'(m_err));
    end
  end

  task automatic bus(bit w_, bit r_, bit s_, logic [7:0] d);
    @(negedge clk); wr = w_; rd = r_; sel = s_; wdata = d;
    @(negedge clk); wr = 0; rd = 0;
  endtask
  task automatic set_idx(logic [7:0] v); bus(1, 0, 0, v); endtask
  task automatic put(logic [7:0] v);     bus(1, 0, 1, v); endtask
  task automatic get(output int v);      bus(0, 1, 1, 8'h00); v = int'(rdata); endtask
  task automatic get_idx(output int v);  bus(0, 1, 0, 8'h00); v = int'(rdata); endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
  endtask
  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 10 * P);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int v, n;
    do_reset();
    check("R4 reset rdata", int'(rdata), 0);
    check("R4 reset err", int'(err), 0);
    check("R4 reset irq", int'(irq), 0);
    get_idx(v); check("R1 index after reset", v, 0);

    // R1 / R3 storage
    set_idx(8'h05); get_idx(v); check("R1 index readback", v, 5);
    put(8'hA5);
    set_idx(8'h00); put(8'h3C);
    set_idx(8'h09); put(8'hFF);
    set_idx(8'h05); get(v); check("R3 byte 5", v, 'hA5);
    set_idx(8'h00); get(v); check("R3 byte 0", v, 'h3C);
    set_idx(8'h09); get(v); check("R3 byte 9", v, 'hFF);
    set_idx(8'h03); get(v); check("R3 unwritten byte", v, 0);
    set_idx(8'h0D); get_idx(v); check("R1 top index accepted", v, 'h0D);
    check("R1 no error on legal index", int'(err), 0);

    // R2 bad index, R11 sticky
    set_idx(8'h09);
    set_idx(8'h0E); get_idx(v); check("R2 bad index ignored", v, 9);
    check("R2 bad index error", int'(err), 1);
    get(v); check("R2 storage still reachable", v, 'hFF);
    repeat (5) @(negedge clk);
    check("R11 error sticky", int'(err), 1);

    // R4 / R5 / R7 register A
    do_reset();
    check("R11 reset clears error", int'(err), 0);
    set_idx(8'h0A);
    get(v); check("R5 first A read", v, 'hA6);
    get(v); check("R5 second A read", v, 'h26);
    get(v); check("R5 third A read", v, 'hA6);
    put(8'h26); check("R7 legal A write no error", int'(err), 0);
    get(v); check("R7 A write clears flag", v, 'hA6);
    put(8'h20); check("R7 bad A write error", int'(err), 1);
    get(v); check("R7 bad A write ignored", v, 'h26);

    // R4 / R6 register B
    do_reset();
    set_idx(8'h0B); get(v); check("R4 reset B", v, 'h46);
    put(8'h0E); check("R6 legal B write no error", int'(err), 0);
    get(v); check("R6 legal B value", v, 'h0E);
    put(8'h4A); check("R6 bad B write error", int'(err), 1);
    get(v); check("R6 bad B write ignored", v, 'h0E);

    // R8 registers C and D
    do_reset();
    set_idx(8'h0C); get(v); check("R8 C reads zero", v, 0);
    set_idx(8'h0D); get(v); check("R8 D reads zero", v, 0);
    check("R8 no error on C/D read", int'(err), 0);
    put(8'h55); check("R8 D write error", int'(err), 1);
    get(v); check("R8 D still zero", v, 0);

    // R12 write wins over read
    do_reset();
    set_idx(8'h05); put(8'h11); get(v); check("R12 read", v, 'h11);
    bus(1, 1, 1, 8'h22); check("R12 rdata holds on write+read", int'(rdata), 'h11);
    get(v); check("R12 write taken", v, 'h22);

    // R9 / R10 periodic interrupt
    do_reset();
    gap(n); check("R9 first pulse after reset", n, P);
    gap(n); check("R9 pulse spacing", n, P);
    set_idx(8'h0B); put(8'h06);
    n = 0;
    repeat (3 * P) begin @(negedge clk); if (irq) n++; end
    check("R10 no pulse while disabled", n, 0);
    put(8'h46);
    gap(n); check("R10 first pulse after enable", n, P);
    put(8'h4E);
    gap(n); check("R10 redundant enable keeps schedule", n + 2, P);
    gap(n); check("R9 spacing after rewrite", n, P);
    check("R6 legal writes no error", int'(err), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule